// File: doc/BRIEF.md
# ECP Forward Command/Data Transmitter

This block moves bytes from two host-side queues onto a forward parallel link. One queue holds command bytes and the other holds plain data bytes. Each byte goes out with a tag line: the host acknowledge output is high for data and low for a command. The byte is then passed across with a four-phase strobe/busy handshake with the peripheral. Command bytes come in two kinds. When the top bit is clear, the low seven bits are a run-length count, and the next data byte is the one the count applies to. When the top bit is set, the low seven bits select a channel. The block does not build runs of its own. It only forwards counts that software has already placed in the command queue.

A mode controller gates the transmitter with an enable and a direction input. A new byte is started only when the transmitter is enabled, the direction is forward and the peripheral is not busy. A byte that is already under way always finishes its handshake. Both queues are read in first-word-fall-through style: the head byte is valid whenever the queue is not empty, and a one-cycle read pulse removes it.

Top module: `ecp_fwd_tx`

## Requirements
- R1: While reset is active, and until the first byte is started, the outputs are: strobe low, both read pulses low, data bus 0x00, host acknowledge high and channel register 0x00.
- R2: A byte taken from the data queue is put on the data bus with host acknowledge high. The data queue gets exactly one read pulse for it.
- R3: A byte taken from the command queue is put on the data bus with host acknowledge low. The command queue gets exactly one read pulse for it.
- R4: When both queues hold bytes and no count is waiting for its data byte, the command is sent before the data byte.
- R5: A command with bit 7 clear is a run-length count. The next byte sent after it comes from the data queue, even if more commands are waiting.
- R6: A command with bit 7 set loads its bits 6..0 into the channel output. A count command leaves the channel output unchanged.
- R7: The strobe rises SETUP_CYCLES+1 clock edges after the read edge of the byte. It stays high until busy is seen high, then falls on the next edge. The data bus and host acknowledge stay stable from that read edge until the next byte is read.
- R8: No byte is started while the enable input is low or the direction input is low (reverse).
- R9: A queue is never read while its empty flag is set.
- R10: No byte is started while busy is high, whether the block is idle or waiting for busy to fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xfer_en_i | input | 1 | Handshake enable from the mode controller |
| dir_fwd_i | input | 1 | 1 = forward direction |
| cmd_empty_i | input | 1 | Command queue empty |
| cmd_rdata_i | input | DW | Command queue head byte |
| cmd_rd_o | output | 1 | Command queue read pulse |
| dat_empty_i | input | 1 | Data queue empty |
| dat_rdata_i | input | DW | Data queue head byte |
| dat_rd_o | output | 1 | Data queue read pulse |
| pd_o | output | DW | Link data bus |
| host_ack_o | output | 1 | Tag line: 1 = data, 0 = command |
| stb_o | output | 1 | Strobe, active high |
| busy_i | input | 1 | Peripheral busy |
| chan_o | output | DW-1 | Last channel address sent |

## Verification
Two things can fall in the same cycle: a command and a data byte both at the head of their queues, and a count whose data byte is still owed while a further command waits. The bench loads both queues while the enable is low, then raises the enable so the arbiter sees both heads in one cycle. It then checks the order and tags in the byte log taken by the peripheral model. A count followed by a channel command and two data bytes must come out interleaved as count, data, channel, data, not as both commands first.

// File: rtl/ecp_fwd_pkg.sv
package ecp_fwd_pkg;

  typedef enum logic [1:0] {
    HS_IDLE    = 2'd0,
    HS_SETUP   = 2'd1,
    HS_STROBE  = 2'd2,
    HS_RELEASE = 2'd3
  } hs_state_e;

  localparam logic ACK_DATA = 1'b1;
  localparam logic ACK_CMD  = 1'b0;

endpackage

// File: rtl/ecp_src_sel.sv
module ecp_src_sel #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          cmd_empty_i,
  input  logic [DW-1:0] cmd_rdata_i,
  input  logic          dat_empty_i,
  input  logic [DW-1:0] dat_rdata_i,
  output logic          cmd_rd_o,
  output logic          dat_rd_o,
  output logic          load_o,
  output logic          load_cmd_o,
  output logic [DW-1:0] load_byte_o
);

  localparam int MSB = DW - 1;

  // set after a count is sent, cleared when its data byte goes out
  logic run_owed_q;
  logic pick_cmd, pick_dat;

  always_comb begin
    pick_cmd = go_i && !cmd_empty_i && !run_owed_q;
    pick_dat = go_i && !pick_cmd && !dat_empty_i;
  end

  assign cmd_rd_o    = pick_cmd;
  assign dat_rd_o    = pick_dat;
  assign load_o      = pick_cmd | pick_dat;
  assign load_cmd_o  = pick_cmd;
  assign load_byte_o = pick_cmd ? cmd_rdata_i : dat_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_owed_q <= 1'b0;
    end else if (pick_cmd && !cmd_rdata_i[MSB]) begin
      run_owed_q <= 1'b1;
    end else if (pick_dat) begin
      run_owed_q <= 1'b0;
    end
  end

endmodule

// File: rtl/ecp_hs_fsm.sv
module ecp_hs_fsm
  import ecp_fwd_pkg::*;
#(
  parameter int SETUP_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic busy_i,
  output logic idle_o,
  output logic stb_o
);

  localparam int CW = (SETUP_CYCLES < 2) ? 1 : $clog2(SETUP_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(SETUP_CYCLES - 1);

  hs_state_e      state_q;
  logic [CW-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        HS_IDLE: begin
          if (load_i) begin
            state_q <= HS_SETUP;
            cnt_q   <= '0;
          end
        end
        HS_SETUP: begin
          if (cnt_q == CNT_LAST) state_q <= HS_STROBE;
          else                   cnt_q   <= cnt_q + CW'(1);
        end
        HS_STROBE: begin
          if (busy_i) state_q <= HS_RELEASE;
        end
        HS_RELEASE: begin
          if (!busy_i) state_q <= HS_IDLE;
        end
        default: state_q <= HS_IDLE;
      endcase
    end
  end

  assign idle_o = (state_q == HS_IDLE);
  assign stb_o  = (state_q == HS_STROBE);

endmodule

// File: rtl/ecp_out_reg.sv
module ecp_out_reg
  import ecp_fwd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          load_cmd_i,
  input  logic [DW-1:0] byte_i,
  output logic [DW-1:0] pd_o,
  output logic          host_ack_o,
  output logic [DW-2:0] chan_o
);

  localparam int MSB = DW - 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_o       <= '0;
      host_ack_o <= ACK_DATA;
      chan_o     <= '0;
    end else if (load_i) begin
      pd_o       <= byte_i;
      host_ack_o <= load_cmd_i ? ACK_CMD : ACK_DATA;
      if (load_cmd_i && byte_i[MSB]) chan_o <= byte_i[MSB-1:0];
    end
  end

endmodule

// File: rtl/ecp_fwd_tx.sv
module ecp_fwd_tx #(
  parameter int DW           = 8,
  parameter int SETUP_CYCLES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          xfer_en_i,
  input  logic          dir_fwd_i,
  input  logic          cmd_empty_i,
  input  logic [DW-1:0] cmd_rdata_i,
  output logic          cmd_rd_o,
  input  logic          dat_empty_i,
  input  logic [DW-1:0] dat_rdata_i,
  output logic          dat_rd_o,
  output logic [DW-1:0] pd_o,
  output logic          host_ack_o,
  output logic          stb_o,
  input  logic          busy_i,
  output logic [DW-2:0] chan_o
);

  logic          idle;
  logic          go;
  logic          load;
  logic          load_cmd;
  logic [DW-1:0] load_byte;

  assign go = xfer_en_i && dir_fwd_i && idle && !busy_i;

  ecp_src_sel #(.DW(DW)) u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .cmd_empty_i (cmd_empty_i),
    .cmd_rdata_i (cmd_rdata_i),
    .dat_empty_i (dat_empty_i),
    .dat_rdata_i (dat_rdata_i),
    .cmd_rd_o    (cmd_rd_o),
    .dat_rd_o    (dat_rd_o),
    .load_o      (load),
    .load_cmd_o  (load_cmd),
    .load_byte_o (load_byte)
  );

  ecp_hs_fsm #(.SETUP_CYCLES(SETUP_CYCLES)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .busy_i (busy_i),
    .idle_o (idle),
    .stb_o  (stb_o)
  );

  ecp_out_reg #(.DW(DW)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_cmd_i (load_cmd),
    .byte_i     (load_byte),
    .pd_o       (pd_o),
    .host_ack_o (host_ack_o),
    .chan_o     (chan_o)
  );

endmodule

// File: rtl/ecp_fwd_tx_chk.sv
module ecp_fwd_tx_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          xfer_en_i,
  input logic          dir_fwd_i,
  input logic          cmd_empty_i,
  input logic [DW-1:0] cmd_rdata_i,
  input logic          cmd_rd_o,
  input logic          dat_empty_i,
  input logic          dat_rd_o,
  input logic [DW-1:0] pd_o,
  input logic          host_ack_o,
  input logic          stb_o,
  input logic          busy_i,
  input logic [DW-2:0] chan_o
);

  logic count_owed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                count_owed <= 1'b0;
    else if (cmd_rd_o && !cmd_rdata_i[DW-1])    count_owed <= 1'b1;
    else if (dat_rd_o)                          count_owed <= 1'b0;
  end

  p_no_empty_pop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_rd_o |-> !cmd_empty_i) and (dat_rd_o |-> !dat_empty_i));

  p_single_pop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_rd_o && dat_rd_o));

  p_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_rd_o || dat_rd_o) |-> (xfer_en_i && dir_fwd_i));

  p_busy_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_rd_o || dat_rd_o) |-> !busy_i);

  p_cmd_tag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rd_o |=> !host_ack_o);

  p_dat_tag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_rd_o |=> host_ack_o);

  p_count_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rd_o |-> !count_owed);

  p_chan_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_rd_o && cmd_rdata_i[DW-1]) |=> (chan_o == $past(cmd_rdata_i[DW-2:0])));

  p_chan_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_rd_o && !cmd_rdata_i[DW-1]) |=> $stable(chan_o));

  p_stb_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_o && !busy_i) |=> stb_o);

  p_stb_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_o && busy_i) |=> !stb_o);

  p_bus_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_rd_o || dat_rd_o) |=> ($stable(pd_o) && $stable(host_ack_o)));

  p_no_pop_in_stb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> !(cmd_rd_o || dat_rd_o));

endmodule

bind ecp_fwd_tx ecp_fwd_tx_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .xfer_en_i   (xfer_en_i),
  .dir_fwd_i   (dir_fwd_i),
  .cmd_empty_i (cmd_empty_i),
  .cmd_rdata_i (cmd_rdata_i),
  .cmd_rd_o    (cmd_rd_o),
  .dat_empty_i (dat_empty_i),
  .dat_rd_o    (dat_rd_o),
  .pd_o        (pd_o),
  .host_ack_o  (host_ack_o),
  .stb_o       (stb_o),
  .busy_i      (busy_i),
  .chan_o      (chan_o)
);

// File: tb/sim_ecp_fwd_tx.sv
`timescale 1ns/1ps
module sim_ecp_fwd_tx;

  localparam int SETUP = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       fwd = 1'b1;
  logic       cmd_rd, dat_rd, ack, stb, busy;
  logic [7:0] pd;
  logic [6:0] chan;

  logic [7:0] cq [0:63];
  logic [7:0] dq [0:63];
  int ch = 0, ct = 0, dh = 0, dt = 0;
  int dat_pops = 0, bad_pops = 0;

  logic auto_mode = 1'b1, a_busy = 1'b0, m_busy = 1'b0;
  logic [7:0] lg_b [0:63];
  logic       lg_a [0:63];
  int ln = 0;

  int checks = 0, errors = 0, cyc = 0;

  wire cmd_empty = (ch == ct);
  wire dat_empty = (dh == dt);
  wire [7:0] cmd_rdata = cq[ch[5:0]];
  wire [7:0] dat_rdata = dq[dh[5:0]];
  assign busy = auto_mode ? a_busy : m_busy;

  always #4 clk = ~clk;

  ecp_fwd_tx #(.DW(8), .SETUP_CYCLES(SETUP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .xfer_en_i(en), .dir_fwd_i(fwd),
    .cmd_empty_i(cmd_empty), .cmd_rdata_i(cmd_rdata), .cmd_rd_o(cmd_rd),
    .dat_empty_i(dat_empty), .dat_rdata_i(dat_rdata), .dat_rd_o(dat_rd),
    .pd_o(pd), .host_ack_o(ack), .stb_o(stb), .busy_i(busy), .chan_o(chan)
  );

  // queue models
  always @(posedge clk) begin
    if (rst_n) begin
      if (cmd_rd) begin
        if (cmd_empty) bad_pops++;
        ch <= ch + 1;
      end
      if (dat_rd) begin
        if (dat_empty) bad_pops++;
        dh <= dh + 1;
        dat_pops++;
      end
    end
  end

  // peripheral model: logs each byte when it raises busy
  always @(negedge clk) begin
    if (!rst_n) a_busy = 1'b0;
    else if (auto_mode) begin
      if (!a_busy && stb) begin
        lg_b[ln[5:0]] = pd;
        lg_a[ln[5:0]] = ack;
        ln++;
        a_busy = 1'b1;
      end else if (a_busy && !stb) begin
        a_busy = 1'b0;
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic push_cmd(input logic [7:0] b);
    cq[ct[5:0]] = b;
    ct++;
  endtask

  task automatic push_dat(input logic [7:0] b);
    dq[dt[5:0]] = b;
    dt++;
  endtask

  task automatic drain();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (cmd_empty && dat_empty && !stb && !busy) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic exp_log(input int idx, input logic [7:0] b, input logic a, input string req);
    chk(lg_b[idx[5:0]] == b, req, int'(lg_b[idx[5:0]]), int'(b));
    chk(lg_a[idx[5:0]] == a, req, int'(lg_a[idx[5:0]]), int'(a));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(stb == 1'b0, "R1 strobe", int'(stb), 0);
    chk(cmd_rd == 1'b0 && dat_rd == 1'b0, "R1 pops", int'({cmd_rd, dat_rd}), 0);
    chk(pd == 8'h00, "R1 bus", int'(pd), 0);
    chk(ack == 1'b1, "R1 ack", int'(ack), 1);
    chk(chan == 7'h00, "R1 chan", int'(chan), 0);
  endtask

  task automatic t_data();
    int base = ln;
    en = 1'b1;
    push_dat(8'h3C); push_dat(8'hF0); push_dat(8'h81);
    drain();
    chk(ln - base == 3, "R2 count", ln - base, 3);
    exp_log(base,     8'h3C, 1'b1, "R2 data0");
    exp_log(base + 1, 8'hF0, 1'b1, "R2 data1");
    exp_log(base + 2, 8'h81, 1'b1, "R2 data2");
  endtask

  task automatic t_prio();
    int base = ln;
    en = 1'b0;
    @(negedge clk);
    push_dat(8'h11); push_cmd(8'h85); push_cmd(8'h22);
    en = 1'b1;
    drain();
    chk(ln - base == 3, "R4 count", ln - base, 3);
    exp_log(base,     8'h85, 1'b0, "R4 R3 chan cmd first");
    exp_log(base + 1, 8'h22, 1'b0, "R3 count cmd");
    exp_log(base + 2, 8'h11, 1'b1, "R4 data last");
    chk(chan == 7'h05, "R6 chan kept over count", int'(chan), 5);
  endtask

  task automatic t_rle();
    int base = ln;
    en = 1'b0;
    @(negedge clk);
    push_cmd(8'h10); push_cmd(8'h83); push_dat(8'hAA); push_dat(8'hBB);
    en = 1'b1;
    drain();
    chk(ln - base == 4, "R5 count", ln - base, 4);
    exp_log(base,     8'h10, 1'b0, "R5 count");
    exp_log(base + 1, 8'hAA, 1'b1, "R5 run byte");
    exp_log(base + 2, 8'h83, 1'b0, "R5 chan after run");
    exp_log(base + 3, 8'hBB, 1'b1, "R5 data");
    chk(chan == 7'h03, "R6 chan load", int'(chan), 3);
  endtask

  task automatic t_gate();
    int p;
    int base = ln;
    en = 1'b0;
    fwd = 1'b1;
    @(negedge clk);
    push_dat(8'h77);
    p = dat_pops;
    repeat (40) @(negedge clk);
    chk(dat_pops == p && !stb, "R8 enable low", dat_pops - p, 0);
    en = 1'b1;
    fwd = 1'b0;
    repeat (40) @(negedge clk);
    chk(dat_pops == p && !stb, "R8 reverse", dat_pops - p, 0);
    fwd = 1'b1;
    drain();
    chk(ln - base == 1, "R8 resumed", ln - base, 1);
    exp_log(base, 8'h77, 1'b1, "R8 byte");
  endtask

  task automatic t_timing();
    int n = 0;
    int p;
    auto_mode = 1'b0;
    m_busy = 1'b0;
    @(negedge clk);
    push_dat(8'h5A);
    #1;
    chk(dat_rd == 1'b1, "R7 pop seen", int'(dat_rd), 1);
    while (!stb && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(n == SETUP + 1, "R7 setup edges", n, SETUP + 1);
    chk(pd == 8'h5A && ack, "R7 bus at strobe", int'(pd), 8'h5A);
    repeat (6) @(negedge clk);
    chk(stb == 1'b1, "R7 strobe held", int'(stb), 1);
    m_busy = 1'b1;
    @(negedge clk);
    chk(stb == 1'b0, "R7 strobe released", int'(stb), 0);
    push_dat(8'h66);
    p = dat_pops;
    repeat (5) @(negedge clk);
    chk(dat_pops == p && pd == 8'h5A, "R10 busy blocks next", dat_pops - p, 0);
    m_busy = 1'b0;
    repeat (4) @(negedge clk);
    chk(dat_pops == p + 1, "R10 resumes after busy low", dat_pops - p, 1);
    chk(pd == 8'h66, "R2 next byte", int'(pd), 8'h66);
    for (int i = 0; i < 50 && !stb; i++) @(negedge clk);
    m_busy = 1'b1;
    for (int i = 0; i < 50 && stb; i++) @(negedge clk);
    m_busy = 1'b0;
    repeat (3) @(negedge clk);
    // busy high while idle
    m_busy = 1'b1;
    @(negedge clk);
    push_dat(8'h99);
    p = dat_pops;
    repeat (6) @(negedge clk);
    chk(dat_pops == p && !stb, "R10 idle busy", dat_pops - p, 0);
    m_busy = 1'b0;
    for (int i = 0; i < 50 && !stb; i++) @(negedge clk);
    chk(pd == 8'h99, "R10 start after busy low", int'(pd), 8'h99);
    m_busy = 1'b1;
    for (int i = 0; i < 50 && stb; i++) @(negedge clk);
    m_busy = 1'b0;
    repeat (3) @(negedge clk);
    auto_mode = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_data();
    t_prio();
    t_rle();
    t_gate();
    t_timing();
    chk(bad_pops == 0, "R9 empty pops", bad_pops, 0);
    summary();
    $finish;
  end

endmodule